// File: doc/BRIEF.md
# Dirty-Row Scanout Walker

This block walks one frame of an 8-bit-per-pixel frame buffer, row by row, and refreshes only the rows that changed. Software marks rows dirty one at a time, or requests a redraw of the whole screen. When a frame is started, the walker takes a snapshot of the dirty rows. For every row it keeps, it reads each pixel byte from the frame buffer. It looks that byte up in a 256-entry colour palette and sends the packed 24-bit colour out on a valid/ready stream.

Consecutive rows that were redrawn are merged into a single update rectangle. A rectangle is given by its first row and its number of rows, and always spans the full width. A downstream compositor uses these rectangles to copy only the regions that changed. When the scan is over and the pixel stream has drained, a one-cycle frame-end strobe is raised, which interrupt logic can use.

The frame buffer read port is asynchronous: the byte at `mem_addr` must be present on `mem_data` in the same cycle.

Top module: `scanout_walker`

## Requirements
- R1: After reset, `px_valid`, `rect_valid` and `frame_end` are low, and the palette is all zero. The full-redraw flag is set by reset, so the first frame processes every row.
- R2: A row y < effective height is processed if the full-redraw flag is set or the row's bit in the frame-start snapshot is set. Any other row produces no pixels.
- R3: Pixels of processed rows go out in ascending row order, and within a row in ascending column order. The pixel at column x of row y is read from byte address y*width + x. It is sent as `px_rgb` = palette[byte], packed as red in [23:16], green in [15:8] and blue in [7:0].
- R4: A processed row that follows a skipped row, or is row 0, opens a run. The first skipped row after a run emits one rectangle with `rect_row` = run start and `rect_rows` = current row − start.
- R5: A run still open after the last row is closed with a rectangle whose row count reaches the effective height. This rectangle appears strictly before `frame_end`.
- R6: `frame_end` is a one-cycle pulse. It comes only after every pixel of the frame has been accepted, and the output stream is empty while it is high.
- R7: `full_req` sets the full-redraw flag. The flag is cleared when a frame completes, so the next frame processes only dirty rows.
- R8: `invalidate` marks every row dirty for the next frame.
- R9: The dirty rows are copied and cleared when a frame starts. A row marked while a scan is running is not processed in that scan, but is processed in the next one.
- R10: While `px_valid` is high and `px_ready` is low, `px_valid` stays high and `px_rgb` does not change. No pixel is dropped or repeated.
- R11: A `height` larger than MAX_ROWS is treated as MAX_ROWS.
- R12: `frame_go` has no effect while a frame is in progress. Exactly one `frame_end` follows each accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_go | input | 1 | Start a frame scan (accepted when idle) |
| width | input | W_BITS | Pixels per row |
| height | input | H_BITS | Rows per frame (clamped to MAX_ROWS) |
| full_req | input | 1 | Set the full-redraw flag |
| invalidate | input | 1 | Mark all rows dirty |
| mark_en | input | 1 | Mark one row dirty |
| mark_row | input | IDX_W | Row to mark |
| pal_we | input | 1 | Palette write enable |
| pal_idx | input | PIX_BITS | Palette entry to write |
| pal_rgb | input | 24 | Colour written {R,G,B} |
| mem_addr | output | ADDR_W | Frame buffer byte address |
| mem_data | input | PIX_BITS | Frame buffer byte at mem_addr (same cycle) |
| px_valid | output | 1 | Pixel stream valid |
| px_ready | input | 1 | Pixel stream ready |
| px_rgb | output | 24 | Pixel colour {R,G,B} |
| rect_valid | output | 1 | Update rectangle event (one cycle) |
| rect_row | output | ROW_W | First row of the rectangle |
| rect_rows | output | ROW_W | Number of rows in the rectangle |
| frame_end | output | 1 | Frame-complete strobe |

## Verification
The hardest case is a row marked dirty while a scan is already running, which must wait for the following frame. The bench creates it by stalling the pixel stream heavily, so that the scan is still on row 0 when it marks a later row. It then runs a frame with no new marks and expects that row alone as a one-row rectangle. Two other cases need a long scan: a second start pulse during a scan, and an open run flushed at the last row under back-pressure. The bench reaches these by combining tall frames with ready patterns that hold the output register full for several cycles.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int RGB_W = 24;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_ROW   = 3'd1,
    S_PIX   = 3'd2,
    S_FLUSH = 3'd3,
    S_DONE  = 3'd4
  } walk_state_t;

  // byte offset of the first pixel of a row
  function automatic int unsigned row_base(input int unsigned row, input int unsigned wid);
    return row * wid;
  endfunction

  // number of rows actually walked
  function automatic int unsigned clamp_rows(input int unsigned h, input int unsigned lim);
    return (h > lim) ? lim : h;
  endfunction
endpackage

// File: rtl/dirty_snap.sv
module dirty_snap #(
  parameter int MAX_ROWS = 32,
  localparam int IDX_W = $clog2(MAX_ROWS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mark_en,
  input  logic [IDX_W-1:0]    mark_row,
  input  logic                invalidate,
  input  logic                take,
  output logic [MAX_ROWS-1:0] snap
);
  logic [MAX_ROWS-1:0] live, live_nxt;

  always_comb begin
    live_nxt = take ? '0 : live;
    if (invalidate) live_nxt = '1;
    if (mark_en)    live_nxt[mark_row] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live <= '0;
      snap <= '0;
    end else begin
      live <= live_nxt;
      if (take) snap <= live;
    end
  end

  // R9: a snapshot leaves no old bit behind in the live map
  a_r9_snap_clears: assert property (@(posedge clk) disable iff (!rst_n)
    take && !invalidate && !mark_en |=> live == '0);
endmodule

// File: rtl/run_track.sv
module run_track #(
  parameter int ROW_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_valid,
  input  logic             step_keep,
  input  logic             flush,
  input  logic [ROW_W-1:0] step_row,
  output logic             rect_valid,
  output logic [ROW_W-1:0] rect_row,
  output logic [ROW_W-1:0] rect_rows
);
  logic             open_q;
  logic [ROW_W-1:0] start_q;
  logic             opens, closes;

  assign opens  = step_valid && step_keep && !open_q;
  assign closes = open_q && ((step_valid && !step_keep) || flush);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q     <= 1'b0;
      start_q    <= '0;
      rect_valid <= 1'b0;
      rect_row   <= '0;
      rect_rows  <= '0;
    end else begin
      rect_valid <= closes;
      if (opens) begin
        open_q  <= 1'b1;
        start_q <= step_row;
      end
      if (closes) begin
        open_q    <= 1'b0;
        rect_row  <= start_q;
        rect_rows <= step_row - start_q;
      end
    end
  end

  // R4: an emitted rectangle always covers at least one row
  a_r4_rect_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    rect_valid |-> rect_rows != '0);
endmodule

// File: rtl/palette_lut.sv
module palette_lut #(
  parameter int PIX_BITS = 8,
  localparam int ENTRIES = 1 << PIX_BITS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [PIX_BITS-1:0]        wr_idx,
  input  logic [scan_pkg::RGB_W-1:0] wr_rgb,
  input  logic [PIX_BITS-1:0]        rd_idx,
  output logic [scan_pkg::RGB_W-1:0] rd_rgb
);
  logic [scan_pkg::RGB_W-1:0] table_q [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) table_q[i] <= '0;
    end else if (we) begin
      table_q[wr_idx] <= wr_rgb;
    end
  end

  assign rd_rgb = table_q[rd_idx];
endmodule

// File: rtl/scanout_walker.sv
module scanout_walker #(
  parameter int W_BITS   = 8,
  parameter int H_BITS   = 8,
  parameter int MAX_ROWS = 32,
  parameter int PIX_BITS = 8,
  localparam int IDX_W  = $clog2(MAX_ROWS),
  localparam int ROW_W  = $clog2(MAX_ROWS + 1),
  localparam int ADDR_W = W_BITS + ROW_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frame_go,
  input  logic [W_BITS-1:0]          width,
  input  logic [H_BITS-1:0]          height,
  input  logic                       full_req,
  input  logic                       invalidate,
  input  logic                       mark_en,
  input  logic [IDX_W-1:0]           mark_row,
  input  logic                       pal_we,
  input  logic [PIX_BITS-1:0]        pal_idx,
  input  logic [scan_pkg::RGB_W-1:0] pal_rgb,
  output logic [ADDR_W-1:0]          mem_addr,
  input  logic [PIX_BITS-1:0]        mem_data,
  output logic                       px_valid,
  input  logic                       px_ready,
  output logic [scan_pkg::RGB_W-1:0] px_rgb,
  output logic                       rect_valid,
  output logic [ROW_W-1:0]           rect_row,
  output logic [ROW_W-1:0]           rect_rows,
  output logic                       frame_end
);
  import scan_pkg::*;

  walk_state_t          state;
  logic [ROW_W-1:0]     y;
  logic [W_BITS-1:0]    x;
  logic                 full_flag;
  logic [MAX_ROWS-1:0]  snap;
  logic [RGB_W-1:0]     lut_rgb;
  logic [ROW_W-1:0]     eff_h;

  // named internal events
  logic take, row_live, keep, accept, load, last_col, finish;

  assign eff_h    = ROW_W'(clamp_rows(32'(height), MAX_ROWS));
  assign take     = (state == S_IDLE) && frame_go;
  assign row_live = (state == S_ROW) && (y < eff_h);
  assign keep     = full_flag || snap[y[IDX_W-1:0]];
  assign accept   = !px_valid || px_ready;
  assign load     = (state == S_PIX) && accept;
  assign last_col = (x == width - 1'b1);
  assign finish   = (state == S_DONE) && !px_valid;
  assign mem_addr = ADDR_W'(row_base(32'(y), 32'(width)) + 32'(x));

  dirty_snap #(.MAX_ROWS(MAX_ROWS)) u_dirty (
    .clk(clk), .rst_n(rst_n), .mark_en(mark_en), .mark_row(mark_row),
    .invalidate(invalidate), .take(take), .snap(snap)
  );

  run_track #(.ROW_W(ROW_W)) u_runs (
    .clk(clk), .rst_n(rst_n), .step_valid(row_live), .step_keep(keep),
    .flush(state == S_FLUSH), .step_row(y),
    .rect_valid(rect_valid), .rect_row(rect_row), .rect_rows(rect_rows)
  );

  palette_lut #(.PIX_BITS(PIX_BITS)) u_pal (
    .clk(clk), .rst_n(rst_n), .we(pal_we), .wr_idx(pal_idx), .wr_rgb(pal_rgb),
    .rd_idx(mem_data), .rd_rgb(lut_rgb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      y         <= '0;
      x         <= '0;
      full_flag <= 1'b1;
      px_valid  <= 1'b0;
      px_rgb    <= '0;
      frame_end <= 1'b0;
    end else begin
      frame_end <= finish;
      if (full_req)    full_flag <= 1'b1;
      else if (finish) full_flag <= 1'b0;

      if (load) begin
        px_valid <= 1'b1;
        px_rgb   <= lut_rgb;
      end else if (px_ready) begin
        px_valid <= 1'b0;
      end

      unique case (state)
        S_IDLE: if (frame_go) begin
          y     <= '0;
          state <= S_ROW;
        end
        S_ROW: begin
          if (y >= eff_h) begin
            state <= S_FLUSH;
          end else if (keep && width != '0) begin
            x     <= '0;
            state <= S_PIX;
          end else begin
            y <= y + 1'b1;
          end
        end
        S_PIX: if (accept) begin
          if (last_col) begin
            y     <= y + 1'b1;
            state <= S_ROW;
          end else begin
            x <= x + 1'b1;
          end
        end
        S_FLUSH: state <= S_DONE;
        S_DONE:  if (!px_valid) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10: a stalled pixel is held unchanged
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid && !px_ready |=> px_valid && $stable(px_rgb));
  // R6: the stream is empty when the frame-end strobe is seen
  a_r6_end_drained: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> !px_valid);
  // R6: the strobe lasts one cycle
  a_r6_end_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end);
  // R5: the last rectangle is never simultaneous with frame end
  a_r5_rect_before_end: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> !rect_valid);
  // R11: pixel fetch stays inside the clamped height
  a_r11_row_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_PIX |-> y < eff_h && y < ROW_W'(MAX_ROWS));
endmodule

// File: tb/tb_scanout_walker.sv
`timescale 1ns/1ps
module tb_scanout_walker;
  localparam int MAXR = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_go = 0, full_req = 0, invalidate = 0, mark_en = 0, pal_we = 0;
  logic [7:0]  width = 0, height = 0, pal_idx = 0;
  logic [4:0]  mark_row = 0;
  logic [23:0] pal_rgb = 0;
  logic [13:0] mem_addr;
  logic [7:0]  mem_data;
  logic        px_valid, px_ready, rect_valid, frame_end;
  logic [23:0] px_rgb;
  logic [5:0]  rect_row, rect_rows;

  always #2 clk = ~clk;

  scanout_walker dut (
    .clk(clk), .rst_n(rst_n), .frame_go(frame_go), .width(width), .height(height),
    .full_req(full_req), .invalidate(invalidate), .mark_en(mark_en), .mark_row(mark_row),
    .pal_we(pal_we), .pal_idx(pal_idx), .pal_rgb(pal_rgb), .mem_addr(mem_addr),
    .mem_data(mem_data), .px_valid(px_valid), .px_ready(px_ready), .px_rgb(px_rgb),
    .rect_valid(rect_valid), .rect_row(rect_row), .rect_rows(rect_rows), .frame_end(frame_end)
  );

  function automatic logic [7:0] fb_f(input int unsigned a);
    return 8'((a * 13 + 7) & 255);
  endfunction
  function automatic logic [23:0] pal_f(input int unsigned i);
    return {8'(i), 8'((i * 3) & 255), 8'(i ^ 32'h5A)};
  endfunction

  assign mem_data = fb_f(32'(mem_addr));

  int tests = 0, fails = 0, cyc = 0, bp = 0;
  int pix_seen = 0, rect_seen = 0;
  logic [23:0] exp_px[$];
  logic [11:0] exp_rc[$];
  logic [MAXR-1:0] live_m = '0;
  bit full_m = 1'b1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    case (bp)
      1:       px_ready <= (cyc % 3) != 0;
      2:       px_ready <= (cyc % 4) == 0;
      default: px_ready <= 1'b1;
    endcase
  end

  always @(negedge clk) if (rst_n) begin
    if (px_valid && px_ready) begin
      pix_seen++;
      if (exp_px.size() == 0) chk(0, "R2 extra pixel", 32'(px_rgb), 0);
      else begin
        logic [23:0] e;
        e = exp_px.pop_front();
        chk(px_rgb == e, "R3 pixel colour", 32'(px_rgb), 32'(e));
      end
    end
    if (rect_valid) begin
      rect_seen++;
      if (exp_rc.size() == 0) chk(0, "R4 extra rect", {rect_row, rect_rows}, 0);
      else begin
        logic [11:0] r;
        r = exp_rc.pop_front();
        chk({rect_row, rect_rows} == r, "R4 rect", 32'({rect_row, rect_rows}), 32'(r));
      end
    end
  end

  task automatic pulse_mark(input int row);
    @(negedge clk); mark_en = 1; mark_row = 5'(row);
    @(negedge clk); mark_en = 0;
    live_m[row] = 1'b1;
  endtask

  task automatic run_frame(input int w, input int h, input bit full, input int mode,
                           input logic [31:0] mask, input int mid_mark, input bit mid_go,
                           input string tag);
    int eh, st, nrc, t;
    bit open, k;
    logic [MAXR-1:0] sm;
    bp = mode;
    width = 8'(w); height = 8'(h);
    for (int r = 0; r < MAXR; r++) if (mask[r]) pulse_mark(r);
    if (full) begin
      @(negedge clk); full_req = 1; @(negedge clk); full_req = 0;
      full_m = 1;
    end
    eh = (h > MAXR) ? MAXR : h;
    sm = live_m; live_m = '0; open = 0; st = 0; nrc = 0;
    for (int r = 0; r < eh; r++) begin
      k = full_m || sm[r];
      if (k) begin
        if (!open) begin open = 1; st = r; end
        for (int c = 0; c < w; c++) exp_px.push_back(pal_f(32'(fb_f(r * w + c))));
      end else if (open) begin
        exp_rc.push_back({6'(st), 6'(r - st)}); nrc++; open = 0;
      end
    end
    if (open) begin exp_rc.push_back({6'(st), 6'(eh - st)}); nrc++; end
    rect_seen = 0;
    @(negedge clk); frame_go = 1; @(negedge clk); frame_go = 0;
    if (mid_mark >= 0) begin @(negedge clk); pulse_mark(mid_mark); end
    if (mid_go) begin @(negedge clk); frame_go = 1; @(negedge clk); frame_go = 0; end
    t = 0;
    while (!frame_end && t < 5000) begin @(negedge clk); t++; end
    chk(frame_end, {tag, " frame_end seen"}, 32'(frame_end), 1);
    chk(exp_px.size() == 0 && exp_rc.size() == 0, {tag, " R5 all output before frame_end"},
        32'(exp_px.size() + exp_rc.size()), 0);
    chk(rect_seen == nrc, {tag, " rect count"}, 32'(rect_seen), 32'(nrc));
    exp_px.delete(); exp_rc.delete();
    full_m = 0;
    @(negedge clk);
    chk(!frame_end, "R6 frame_end one cycle", 32'(frame_end), 0);
    if (mid_go) begin
      bit quiet;
      quiet = 1;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (frame_end || px_valid || rect_valid) quiet = 0;
      end
      chk(quiet, "R12 second start ignored", 32'(quiet), 1);
    end
  endtask

  typedef struct packed {
    logic [7:0]  w;
    logic [7:0]  h;
    logic        full;
    logic [1:0]  bp;
    logic [31:0] mask;
  } vec_t;

  localparam vec_t VECS[8] = '{
    '{w:8'd4, h:8'd6,  full:1'b0, bp:2'd0, mask:32'h0},        // R1: full after reset
    '{w:8'd5, h:8'd8,  full:1'b0, bp:2'd1, mask:32'h6D},       // R2 R4 R7
    '{w:8'd3, h:8'd8,  full:1'b0, bp:2'd2, mask:32'hC0},       // R5 flush at end
    '{w:8'd2, h:8'd5,  full:1'b0, bp:2'd0, mask:32'h0},        // R9 cleared snapshot
    '{w:8'd6, h:8'd4,  full:1'b1, bp:2'd1, mask:32'h1},        // R7 full request
    '{w:8'd1, h:8'd32, full:1'b0, bp:2'd0, mask:32'hAAAAAAAA}, // R4 many runs
    '{w:8'd7, h:8'd40, full:1'b1, bp:2'd2, mask:32'h0},        // R11 clamp
    '{w:8'd9, h:8'd3,  full:1'b0, bp:2'd1, mask:32'h5}         // R10 stalls
  };

  initial begin
    repeat (3) @(negedge clk);
    chk(!px_valid && !rect_valid && !frame_end, "R1 reset outputs", {px_valid, rect_valid, frame_end}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!px_valid && !rect_valid && !frame_end, "R1 idle after reset", {px_valid, rect_valid, frame_end}, 0);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk); pal_we = 1; pal_idx = 8'(i); pal_rgb = pal_f(i);
    end
    @(negedge clk); pal_we = 0;

    for (int v = 0; v < 8; v++)
      run_frame(int'(VECS[v].w), int'(VECS[v].h), VECS[v].full, int'(VECS[v].bp),
                VECS[v].mask, -1, 0, $sformatf("vec%0d R2", v));

    // R8: invalidate marks every row
    @(negedge clk); invalidate = 1; @(negedge clk); invalidate = 0;
    live_m = '1;
    run_frame(2, 4, 0, 0, 32'h0, -1, 0, "R8 invalidate");

    // R9: mark during a stalled scan waits for the next frame
    run_frame(8, 4, 0, 2, 32'h1, 3, 0, "R9 mid-scan mark");
    run_frame(8, 4, 0, 0, 32'h0, -1, 0, "R9 next frame");

    // R12: start pulse during a scan
    run_frame(3, 6, 1, 2, 32'h0, -1, 1, "R12 busy start");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule